// File: doc/BRIEF.md
# Dual-Operation Bank Arbiter

This block sits in front of a multi-bank flash array and decides, one request per cycle, whether a program, erase, suspend, resume, read or status-clear request may act. It keeps one erase slot and one program slot, each with its own block address, a running/suspended flag and a completion timer. At most one of them runs at any moment. The other one is either idle or suspended. This gives a two-deep suspend nest: an erase can be parked so that a program can run elsewhere, and that program can in turn be parked so that reads can proceed.

Reads to banks other than the running operation's bank are served from the array with no added latency. A read to the running bank returns the status word instead. Completions and rejected sequences are recorded in a status word. Operation length is modelled by down-counters with parameterised cycle counts. No cell timing is modelled.

Top module: `dualop_bank_arbiter`

## Requirements
- R1: After reset no operation is active, `busy_valid` and `rsp_valid` are 0, and `status` reads 8'h01 (only the ready bit set).
- R2: Request codes on `req_op` are: 0 idle, 1 read, 2 program, 3 erase, 4 suspend, 5 resume, 6 clear status, 7 idle.
- R3: An erase request is accepted only when neither a program nor an erase is active.
- R4: A program request is accepted only when no program is active and one of the following holds:
  - no erase is active, or
  - the active erase is suspended and targets a different block.
- R5: A program or erase request that is not accepted gets `rsp_ok`=0. It also sets the sticky sequence-error bit (status bit 3).
- R6: At most one operation runs (is active and not suspended) at a time. While one runs, `busy_valid`=1 and `busy_bank` is its bank. The bank number is the upper `BANK_W` bits of the block address.
- R7: Every read gets `rsp_ok`=1 one cycle later. `rsp_status`=1 exactly when the read's bank equals the bank of the running operation. Otherwise `rsp_status` is 0 and the read goes to the array.
- R8: Suspend parks a running program if there is one. Otherwise it parks a running erase. With nothing running it is ignored, with `rsp_ok`=0 and no state change.
- R9: Resume restarts a suspended program first. It restarts a suspended erase only when no program is active. In every other case it is ignored, with `rsp_ok`=0 and no state change.
- R10: A program completes after `PROG_CYCLES` cycles spent running, and an erase after `ERASE_CYCLES` cycles spent running. Suspended cycles do not count. A suspend that arrives in the final cycle parks the operation instead of letting it complete.
- R11: The status word has these bits:
  - bit 0: ready, meaning nothing is running.
  - bit 1: erase suspended.
  - bit 2: program suspended.
  - bit 3: sequence error.
  - bit 4: program done, which is sticky.
  - bit 5: erase done, which is sticky.
  - bits 7:6 read as zero.
- R12: Clear status resets bits 3, 4 and 5 and answers `rsp_ok`=1. A completion in the same cycle still sets its done bit.
- R13: Every non-idle request gets `rsp_valid`=1 in the next cycle. `rsp_ok` and `rsp_status` are computed from the state before that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 3 | Request code (see R2) |
| req_block | input | BANK_W+BLK_IN_W | Target block address, bank in upper bits |
| rsp_valid | output | 1 | A response to last cycle's request is present |
| rsp_ok | output | 1 | Request was accepted or acted upon |
| rsp_status | output | 1 | Read answered with status instead of array data |
| busy_valid | output | 1 | An operation is running |
| busy_bank | output | BANK_W | Bank of the running operation |
| status | output | 8 | Status word (see R11) |

## Verification
The assertions assume that `req_op` carries one of the eight codes every cycle, with no X, and that the cycle counts are at least 1. The stimulus drives only defined codes and block addresses from its own range of values, and it changes them only on the falling edge.

The directed part walks the full suspend nest: an erase, then a program in another bank, then a suspend of each, followed by resumes in reverse order and one extra resume that must be ignored. It also exercises rejected requests, including a program aimed at the suspended erase's own block. A random phase follows, weighted toward suspend and resume so that many completion and suspend collisions occur.

// File: rtl/dualop_pkg.sv
package dualop_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_READ    = 3'd1,
    OP_PROGRAM = 3'd2,
    OP_ERASE   = 3'd3,
    OP_SUSPEND = 3'd4,
    OP_RESUME  = 3'd5,
    OP_CLEAR   = 3'd6,
    OP_IDLE2   = 3'd7
  } op_e;

  localparam int ST_READY   = 0;
  localparam int ST_ESUSP   = 1;
  localparam int ST_PSUSP   = 2;
  localparam int ST_SEQERR  = 3;
  localparam int ST_PDONE   = 4;
  localparam int ST_EDONE   = 5;
  localparam int ST_W       = 8;
endpackage

// File: rtl/dualop_slot.sv
module dualop_slot #(
  parameter int CYCLES = 8,
  parameter int BLK_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [BLK_W-1:0] start_block,
  input  logic             suspend,
  input  logic             resume,
  output logic             active,
  output logic             suspended,
  output logic [BLK_W-1:0] block,
  output logic             done
);
  localparam int CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt;
  logic             running;

  assign running = active && !suspended;
  assign done    = running && !suspend && (cnt == CNT_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      suspended <= 1'b0;
      cnt       <= '0;
      block     <= '0;
    end else if (start) begin
      active    <= 1'b1;
      suspended <= 1'b0;
      cnt       <= CNT_LOAD;
      block     <= start_block;
    end else if (running) begin
      if (suspend)          suspended <= 1'b1;
      else if (cnt == CNT_ONE) active <= 1'b0;
      else                  cnt       <= cnt - CNT_ONE;
    end else if (active && resume) begin
      suspended <= 1'b0;
    end
  end

  // R10: the remaining count stays within the loaded range while active
  a_r10_cnt_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt >= CNT_ONE && cnt <= CNT_LOAD));
  // R10: a suspended slot keeps its count
  a_r10_hold_when_parked: assert property (@(posedge clk) disable iff (rst)
    (active && suspended && !start) |=> $stable(cnt));
  a_r8_parked_is_active: assert property (@(posedge clk) disable iff (rst)
    suspended |-> active);
endmodule

// File: rtl/dualop_decide.sv
module dualop_decide
  import dualop_pkg::*;
#(
  parameter int BLK_W    = 5,
  parameter int BLK_IN_W = 3
) (
  input  logic [2:0]       req_op,
  input  logic [BLK_W-1:0] req_block,
  input  logic             p_act,
  input  logic             p_sus,
  input  logic [BLK_W-1:0] p_blk,
  input  logic             e_act,
  input  logic             e_sus,
  input  logic [BLK_W-1:0] e_blk,
  output logic             p_start,
  output logic             e_start,
  output logic             p_suspend,
  output logic             e_suspend,
  output logic             p_resume,
  output logic             e_resume,
  output logic             ok,
  output logic             rd_status,
  output logic             seq_err,
  output logic             clear
);
  localparam int BANK_W = BLK_W - BLK_IN_W;

  logic p_run, e_run, p_bank_hit, e_bank_hit;
  op_e  op;

  assign op    = op_e'(req_op);
  assign p_run = p_act && !p_sus;
  assign e_run = e_act && !e_sus;
  assign p_bank_hit = (req_block[BLK_W-1 -: BANK_W] == p_blk[BLK_W-1 -: BANK_W]);
  assign e_bank_hit = (req_block[BLK_W-1 -: BANK_W] == e_blk[BLK_W-1 -: BANK_W]);

  always_comb begin
    p_start = 1'b0; e_start = 1'b0;
    p_suspend = 1'b0; e_suspend = 1'b0;
    p_resume = 1'b0; e_resume = 1'b0;
    ok = 1'b0; rd_status = 1'b0; seq_err = 1'b0; clear = 1'b0;
    case (op)
      OP_READ: begin
        ok        = 1'b1;
        rd_status = (p_run && p_bank_hit) || (e_run && e_bank_hit);
      end
      OP_PROGRAM: begin
        if (!p_act && (!e_act || (e_sus && req_block != e_blk))) begin
          p_start = 1'b1; ok = 1'b1;
        end else seq_err = 1'b1;
      end
      OP_ERASE: begin
        if (!p_act && !e_act) begin
          e_start = 1'b1; ok = 1'b1;
        end else seq_err = 1'b1;
      end
      OP_SUSPEND: begin
        if (p_run) begin
          p_suspend = 1'b1; ok = 1'b1;
        end else if (e_run && !p_act) begin
          e_suspend = 1'b1; ok = 1'b1;
        end
      end
      OP_RESUME: begin
        if (p_act && p_sus) begin
          p_resume = 1'b1; ok = 1'b1;
        end else if (e_act && e_sus && !p_act) begin
          e_resume = 1'b1; ok = 1'b1;
        end
      end
      OP_CLEAR: begin
        clear = 1'b1; ok = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dualop_bank_arbiter.sv
module dualop_bank_arbiter
  import dualop_pkg::*;
#(
  parameter int NUM_BANKS       = 4,
  parameter int BLOCKS_PER_BANK = 4,
  parameter int PROG_CYCLES     = 6,
  parameter int ERASE_CYCLES    = 20,
  parameter int BANK_W          = $clog2(NUM_BANKS),
  parameter int BLK_IN_W        = $clog2(BLOCKS_PER_BANK)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [2:0]                 req_op,
  input  logic [BANK_W+BLK_IN_W-1:0] req_block,
  output logic                       rsp_valid,
  output logic                       rsp_ok,
  output logic                       rsp_status,
  output logic                       busy_valid,
  output logic [BANK_W-1:0]          busy_bank,
  output logic [ST_W-1:0]            status
);
  localparam int BLK_W = BANK_W + BLK_IN_W;

  logic             p_start, e_start, p_suspend, e_suspend, p_resume, e_resume;
  logic             ok, rd_status, seq_set, clear;
  logic             p_act, p_sus, p_done, e_act, e_sus, e_done;
  logic [BLK_W-1:0] p_blk, e_blk;
  logic             seq_err_q, p_done_q, e_done_q;
  logic             p_run, e_run;

  dualop_decide #(.BLK_W(BLK_W), .BLK_IN_W(BLK_IN_W)) u_decide (
    .req_op(req_op), .req_block(req_block),
    .p_act(p_act), .p_sus(p_sus), .p_blk(p_blk),
    .e_act(e_act), .e_sus(e_sus), .e_blk(e_blk),
    .p_start(p_start), .e_start(e_start),
    .p_suspend(p_suspend), .e_suspend(e_suspend),
    .p_resume(p_resume), .e_resume(e_resume),
    .ok(ok), .rd_status(rd_status), .seq_err(seq_set), .clear(clear)
  );

  dualop_slot #(.CYCLES(PROG_CYCLES), .BLK_W(BLK_W)) u_prog (
    .clk(clk), .rst(rst), .start(p_start), .start_block(req_block),
    .suspend(p_suspend), .resume(p_resume),
    .active(p_act), .suspended(p_sus), .block(p_blk), .done(p_done)
  );

  dualop_slot #(.CYCLES(ERASE_CYCLES), .BLK_W(BLK_W)) u_erase (
    .clk(clk), .rst(rst), .start(e_start), .start_block(req_block),
    .suspend(e_suspend), .resume(e_resume),
    .active(e_act), .suspended(e_sus), .block(e_blk), .done(e_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      rsp_status <= 1'b0;
      seq_err_q  <= 1'b0;
      p_done_q   <= 1'b0;
      e_done_q   <= 1'b0;
    end else begin
      rsp_valid  <= (req_op != OP_IDLE) && (req_op != OP_IDLE2);
      rsp_ok     <= ok;
      rsp_status <= rd_status;
      seq_err_q  <= (seq_err_q && !clear) || seq_set;
      p_done_q   <= (p_done_q && !clear) || p_done;
      e_done_q   <= (e_done_q && !clear) || e_done;
    end
  end

  assign p_run      = p_act && !p_sus;
  assign e_run      = e_act && !e_sus;
  assign busy_valid = p_run || e_run;
  assign busy_bank  = p_run ? p_blk[BLK_W-1 -: BANK_W]
                    : (e_run ? e_blk[BLK_W-1 -: BANK_W] : '0);

  always_comb begin
    status             = '0;
    status[ST_READY]   = !busy_valid;
    status[ST_ESUSP]   = e_sus;
    status[ST_PSUSP]   = p_sus;
    status[ST_SEQERR]  = seq_err_q;
    status[ST_PDONE]   = p_done_q;
    status[ST_EDONE]   = e_done_q;
  end

  // R6: the two slots never run together
  a_r6_single_running: assert property (@(posedge clk) disable iff (rst)
    !(p_run && e_run));
  // R4: a program coexists with an erase only while the erase is parked
  a_r4_erase_parked: assert property (@(posedge clk) disable iff (rst)
    (p_act && e_act) |-> e_sus);
  // R5: the sequence error only rises after a program or erase request
  a_r5_seq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(seq_err_q) |-> ($past(req_op) == OP_PROGRAM || $past(req_op) == OP_ERASE));
  // R9: an erase is only released once no program is active
  a_r9_resume_order: assert property (@(posedge clk) disable iff (rst)
    ($fell(e_sus) && e_act) |-> !$past(p_act));
  // R8: a program is parked only by a suspend request
  a_r8_park_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(p_sus) |-> ($past(req_op) == OP_SUSPEND));
  // R13: a response never appears without a preceding request
  a_r13_rsp_cause: assert property (@(posedge clk) disable iff (rst)
    rsp_ok |-> rsp_valid);
endmodule

// File: tb/dualop_bank_arbiter_tb.sv
module dualop_bank_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, BPB = 4, PC = 6, EC = 20;
  localparam int BW = 2, IW = 2, KW = 4;
  localparam int WATCHDOG = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    req_op = 3'd0;
  logic [KW-1:0] req_block = '0;
  logic          rsp_valid, rsp_ok, rsp_status, busy_valid;
  logic [BW-1:0] busy_bank;
  logic [7:0]    status;

  int checks = 0, errors = 0, cycles = 0;

  // behavioural model state
  bit m_pa, m_ps, m_ea, m_es, m_seq, m_pd, m_ed, m_rv, m_ok, m_rs;
  int m_pb, m_eb, m_pc, m_ec;

  dualop_bank_arbiter #(.NUM_BANKS(NB), .BLOCKS_PER_BANK(BPB),
    .PROG_CYCLES(PC), .ERASE_CYCLES(EC)) u_dut (
    .clk(clk), .rst(rst), .req_op(req_op), .req_block(req_block),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_status(rsp_status),
    .busy_valid(busy_valid), .busy_bank(busy_bank), .status(status));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int bank_of(int b);
    return b / BPB;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pa = 0; m_ps = 0; m_ea = 0; m_es = 0; m_seq = 0; m_pd = 0; m_ed = 0;
      m_rv = 0; m_ok = 0; m_rs = 0; m_pb = 0; m_eb = 0; m_pc = 0; m_ec = 0;
    end else begin
      int op, blk;
      bit prun, erun, psus_now, esus_now;
      op = req_op; blk = req_block;
      prun = m_pa && !m_ps; erun = m_ea && !m_es;
      psus_now = 0; esus_now = 0;
      m_rv = (op != 0 && op != 7); m_ok = 0; m_rs = 0;
      if (op == 6) begin m_seq = 0; m_pd = 0; m_ed = 0; m_ok = 1; end
      if (op == 1) begin
        m_ok = 1;
        m_rs = (prun && bank_of(blk) == bank_of(m_pb)) || (erun && bank_of(blk) == bank_of(m_eb));
      end
      if (op == 4) begin
        if (prun) begin psus_now = 1; m_ok = 1; end
        else if (erun && !m_pa) begin esus_now = 1; m_ok = 1; end
      end
      // count running operations (pre-state)
      if (prun && !psus_now) begin
        if (m_pc == 1) begin m_pa = 0; m_pd = 1; end else m_pc--;
      end
      if (erun && !esus_now) begin
        if (m_ec == 1) begin m_ea = 0; m_ed = 1; end else m_ec--;
      end
      if (psus_now) m_ps = 1;
      if (esus_now) m_es = 1;
      if (op == 2) begin
        if (!(prun || m_ps) && (!(erun || m_es) || (m_es && blk != m_eb))) begin
          m_pa = 1; m_ps = 0; m_pc = PC; m_pb = blk; m_ok = 1;
        end else m_seq = 1;
      end
      if (op == 3) begin
        if (!(prun || m_ps) && !(erun || m_es)) begin
          m_ea = 1; m_es = 0; m_ec = EC; m_eb = blk; m_ok = 1;
        end else m_seq = 1;
      end
      if (op == 5) begin
        if (m_ps) begin m_ps = 0; m_ok = 1; end
        else if (m_es && !(prun || m_ps)) begin m_es = 0; m_ok = 1; end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare every cycle on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      int exp_st, run_bank;
      bit busy;
      busy = (m_pa && !m_ps) || (m_ea && !m_es);
      run_bank = (m_pa && !m_ps) ? bank_of(m_pb) : ((m_ea && !m_es) ? bank_of(m_eb) : 0);
      exp_st = (busy ? 0 : 1) | (m_es << 1) | (m_ps << 2) | (m_seq << 3) | (m_pd << 4) | (m_ed << 5);
      chk("R11 R10 R12 status", status, exp_st);
      chk("R6 busy_valid", busy_valid, busy);
      chk("R6 busy_bank", busy_bank, run_bank);
      chk("R13 rsp_valid", rsp_valid, m_rv);
      chk("R3 R4 R5 R8 R9 rsp_ok", rsp_ok, m_ok);
      chk("R7 rsp_status", rsp_status, m_rs);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic req(int op, int blk);
    @(negedge clk);
    req_op = 3'(op); req_block = KW'(blk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) req(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 status", status, 8'h01);
    chk("R1 busy_valid", busy_valid, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    rst = 1'b0;
    // R2 codes: program bank 1 then reads to its bank and another
    req(2, 5); req(1, 6); req(1, 12); idle(PC + 2);
    // R3: erase, then a second erase and a program are rejected (R5)
    req(3, 2); req(3, 9); req(2, 9); req(6, 0);
    // R8: park erase, program in another bank, read during program
    req(4, 0); req(2, 2); req(2, 13); req(1, 13); req(1, 0);
    // R8: park program, read, R9: resume erase ignored while program active? resume program first
    req(4, 0); req(1, 13); req(5, 0); idle(2);
    req(4, 0); req(5, 0); idle(PC + 1);
    // R9: now resume erase, then extra resume is ignored
    req(5, 0); req(5, 0); req(4, 0); req(4, 0); req(5, 0); idle(EC + 2);
    // R10: suspend exactly in final program cycle
    req(2, 3); idle(PC - 1); req(4, 0); idle(2); req(5, 0); idle(3);
    // R12: clear with nothing pending
    req(6, 0); req(7, 0); idle(2);
    // random phase, weighted to suspend/resume
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 11);
      case (r)
        0, 1: req(1, $urandom_range(0, 15));
        2, 3: req(2, $urandom_range(0, 15));
        4:    req(3, $urandom_range(0, 15));
        5, 6: req(4, 0);
        7, 8: req(5, 0);
        9:    req(6, 0);
        default: req(0, 0);
      endcase
    end
    idle(3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule